// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a real page address by walking a chain of in-memory translation tables. A request carries a 64-bit virtual address, a write flag and a 2-bit address-space mode. The mode picks one of three root descriptors, which are supplied on plain input pins. The type field of the selected root sets how deep the walk starts. The walk can begin at any of three region tables or at the segment table, and it always ends at a page table. Each table entry is one 64-bit word, fetched through a single read port. The read port has a valid/ready request channel and a response channel that carries only a valid flag.

The walker runs one translation at a time. A request is accepted only while `req_ready` is high, and `req_ready` is high only while the walker is idle. An upstream source that sees `req_ready` low must hold `req_valid` and its fields stable. The walker applies back-pressure through `req_ready` for the whole walk. On the memory side, `mem_req_valid` and `mem_req_addr` stay asserted and unchanged until `mem_req_ready` is sampled high. The walker issues exactly one read per handshake. It expects exactly one `mem_rsp_valid` pulse for each read, arriving after the request handshake. It accepts that response in any cycle and never stalls it.

When the walk finishes, `done` is high for one cycle. In that cycle the result pins hold the real address and the write-allowed flag, or a fault code and an exception word. The result pins keep their values until the next walk completes.

Top module: `pt_walker`

## Requirements
- R1: Mode 1 selects `root_pri`, mode 2 selects `root_sec` and mode 3 selects `root_home`. With translation enabled, mode 0 ends in fault 1 with no memory read, and its exception word is the page address.
- R2: When `xlate_en` is low, the result is the page address with write allowed and fault 0. No memory read is made, and `done` rises in the cycle after the request is accepted.
- R3: The root type is held in root bits [3:2]. Root type 2 requires vaddr bits [63:53] to be zero, root type 1 requires bits [63:42] to be zero, and root type 0 requires bits [63:31] to be zero. A violation gives fault 1 with no memory read. Root type 3 accepts any address.
- R4: A root with bit 5 set (real space) passes the page address through with write allowed, fault 0 and no memory read.
- R5: The walk starts at table level = root type, where 3, 2 and 1 are the region levels and 0 is the segment level, and then ends with the page table. For level k, the entry address is origin + ((vpage >> (17+11k)) & 0x3ff8). For the page table it is origin + ((vpage >> 9) & 0x7f8). The origin comes from bits [63:12] of the root or of a region entry, and from bits [63:11] of a segment entry.
- R6: A region or segment entry whose bits [3:2] differ from the level it was read at gives fault 1.
- R7: A region or segment entry with bit 5 set gives fault 2 (segment translation). A page entry with bit 10 set gives fault 3 (page translation). The invalid check comes before the type check.
- R8: A page entry with bit 9 set (read-only) returns write-allowed 0 for a read. For a write it gives fault 4 (protection).
- R9: On success, the real address is page-entry bits [63:12] with 12 zero bits below, and the exception word is 0. On any fault, the real address and the write-allowed flag are 0, and the exception word is the page address ORed with the mode value. Fault 4 also sets the value-4 bit.
- R10: Exactly one walk is in flight at a time. `req_ready` is high only when idle, and `done` is a single-cycle pulse.
- R11: A memory request that is not accepted keeps `mem_req_valid` high and `mem_req_addr` stable. Every request address is 8-byte aligned.
- R12: Virtual address bits [11:0] have no effect on the reads or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en | input | 1 | Address translation enable |
| root_pri | input | 64 | Root descriptor for mode 1 |
| root_sec | input | 64 | Root descriptor for mode 2 |
| root_home | input | 64 | Root descriptor for mode 3 |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | Request is a write access |
| req_mode | input | 2 | Address-space mode (1,2,3; 0 reserved) |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read |
| done | output | 1 | One-cycle completion pulse |
| res_raddr | output | 64 | Real page address |
| res_write_ok | output | 1 | Writes permitted to the page |
| res_fault | output | 3 | 0 none, 1 specification, 2 segment, 3 page, 4 protection |
| res_exc_word | output | 64 | Exception word |

## Verification
Several properties are checked on every cycle: `done` lasts one cycle, and a busy walker is never ready. A stalled read request holds its address, and read addresses are aligned. Completions carry a legal fault code and a page-aligned real address. A fault clears the result, and a protection fault sets the value-4 bit of the word. Other behaviour can only be shown by the bench scenarios, because it depends on table contents. These scenarios cover the starting level and the sequence of read addresses for each root type. They also cover invalid and mistyped entries at chosen levels, read-only pages under reads and writes, range rejection, the real-space and translation-off bypasses, and walks with memory stalls.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W        = 64;
  localparam int PAGE_SHIFT  = 12;
  localparam int SEG_SHIFT   = 11;
  localparam int NUM_TBL     = 4;
  localparam int LVL_W       = $clog2(NUM_TBL);
  localparam int TYPE_LO     = 2;
  localparam int REAL_BIT    = 5;
  localparam int ENT_INV_BIT = 5;
  localparam int PG_INV_BIT  = 10;
  localparam int PG_RO_BIT   = 9;
  localparam int BASE_SHIFT  = 17;
  localparam int STEP_SHIFT  = 11;
  localparam int PG_IDX_SHIFT = 9;
  localparam logic [VA_W-1:0] TBL_IDX_MASK = 64'h3ff8;
  localparam logic [VA_W-1:0] PG_IDX_MASK  = 64'h07f8;
  localparam logic [VA_W-1:0] RANGE_L2     = 64'hffe0_0000_0000_0000;
  localparam logic [VA_W-1:0] RANGE_L1     = 64'hffff_fc00_0000_0000;
  localparam logic [VA_W-1:0] RANGE_L0     = 64'hffff_ffff_8000_0000;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_SPEC = 3'd1,
    FLT_SEG  = 3'd2,
    FLT_PAGE = 3'd3,
    FLT_PROT = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_e;

  typedef struct packed {
    logic [VA_W-1:0] raddr;
    logic            wok;
    fault_e          fault;
    logic [VA_W-1:0] word;
  } walk_res_t;

  function automatic int unsigned tbl_shift(input int unsigned lvl);
    return BASE_SHIFT + STEP_SHIFT * lvl;
  endfunction
endpackage

// File: rtl/ptw_root_sel.sv
module ptw_root_sel
  import ptw_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [VA_W-1:0]  root_pri,
  input  logic [VA_W-1:0]  root_sec,
  input  logic [VA_W-1:0]  root_home,
  input  logic [VA_W-1:0]  vpage,
  output logic             mode_ok,
  output logic             range_ok,
  output logic             real_space,
  output logic [LVL_W-1:0] start_lvl,
  output logic [VA_W-1:0]  root_origin
);
  logic [VA_W-1:0] root;
  logic [VA_W-1:0] range_mask;

  always_comb begin
    unique case (mode)
      2'd1:    root = root_pri;
      2'd2:    root = root_sec;
      2'd3:    root = root_home;
      default: root = '0;
    endcase
  end

  assign mode_ok     = (mode != 2'd0);
  assign start_lvl   = root[TYPE_LO +: LVL_W];
  assign real_space  = root[REAL_BIT];
  assign root_origin = {root[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

  always_comb begin
    unique case (start_lvl)
      2'd2:    range_mask = RANGE_L2;
      2'd1:    range_mask = RANGE_L1;
      2'd0:    range_mask = RANGE_L0;
      default: range_mask = '0;
    endcase
  end

  assign range_ok = ((vpage & range_mask) == '0);

  logic unused_root_bits;
  assign unused_root_bits = ^{root[PAGE_SHIFT-1:REAL_BIT+1], root[REAL_BIT-1:TYPE_LO+LVL_W],
                              root[TYPE_LO-1:0]};
endmodule

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  vpage,
  input  logic [VA_W-1:0]  origin,
  input  logic [LVL_W-1:0] lvl,
  input  logic             at_page,
  output logic [VA_W-1:0]  entry_addr
);
  logic [VA_W-1:0] lvl_off [NUM_TBL];
  logic [VA_W-1:0] page_off;

  for (genvar g = 0; g < NUM_TBL; g++) begin : g_off
    assign lvl_off[g] = (vpage >> tbl_shift(g)) & TBL_IDX_MASK;
  end

  assign page_off   = (vpage >> PG_IDX_SHIFT) & PG_IDX_MASK;
  assign entry_addr = origin + (at_page ? page_off : lvl_off[lvl]);
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]  entry,
  input  logic [LVL_W-1:0] lvl,
  input  logic             at_page,
  input  logic             is_write,
  output fault_e           fault,
  output logic [VA_W-1:0]  next_origin,
  output logic [VA_W-1:0]  frame,
  output logic             wok
);
  logic seg_last;
  assign seg_last = (lvl == '0);

  always_comb begin
    fault       = FLT_NONE;
    next_origin = seg_last ? {entry[VA_W-1:SEG_SHIFT], {SEG_SHIFT{1'b0}}}
                           : {entry[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    frame       = {entry[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    wok         = !entry[PG_RO_BIT];
    if (at_page) begin
      if (entry[PG_INV_BIT])
        fault = FLT_PAGE;
      else if (entry[PG_RO_BIT] && is_write)
        fault = FLT_PROT;
    end else begin
      if (entry[ENT_INV_BIT])
        fault = FLT_SEG;
      else if (entry[TYPE_LO +: LVL_W] != lvl)
        fault = FLT_SPEC;
    end
  end

  logic unused_ent_bits;
  assign unused_ent_bits = ^{entry[8:6], entry[4], entry[1:0]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xlate_en,
  input  logic [63:0] root_pri,
  input  logic [63:0] root_sec,
  input  logic [63:0] root_home,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic        req_write,
  input  logic [1:0]  req_mode,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic [63:0] res_raddr,
  output logic        res_write_ok,
  output logic [2:0]  res_fault,
  output logic [63:0] res_exc_word
);
  walk_state_e      state;
  logic [VA_W-1:0]  vpage_q;
  logic             wr_q;
  logic [1:0]       mode_q;
  logic [LVL_W-1:0] lvl_q;
  logic             at_page_q;
  logic [VA_W-1:0]  origin_q;
  walk_res_t        res_q;

  logic [VA_W-1:0]  vpage_in;
  assign vpage_in = {req_vaddr[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

  logic             mode_ok, range_ok, real_space;
  logic [LVL_W-1:0] start_lvl;
  logic [VA_W-1:0]  root_origin;

  ptw_root_sel u_root (
    .mode        (req_mode),
    .root_pri    (root_pri),
    .root_sec    (root_sec),
    .root_home   (root_home),
    .vpage       (vpage_in),
    .mode_ok     (mode_ok),
    .range_ok    (range_ok),
    .real_space  (real_space),
    .start_lvl   (start_lvl),
    .root_origin (root_origin)
  );

  ptw_index_gen u_idx (
    .vpage      (vpage_q),
    .origin     (origin_q),
    .lvl        (lvl_q),
    .at_page    (at_page_q),
    .entry_addr (mem_req_addr)
  );

  fault_e          ev_fault;
  logic [VA_W-1:0] ev_next, ev_frame;
  logic            ev_wok;

  ptw_entry_eval u_eval (
    .entry       (mem_rsp_data),
    .lvl         (lvl_q),
    .at_page     (at_page_q),
    .is_write    (wr_q),
    .fault       (ev_fault),
    .next_origin (ev_next),
    .frame       (ev_frame),
    .wok         (ev_wok)
  );

  // Result of a request decided without any table read
  walk_res_t quick_res;
  logic      quick_end;
  always_comb begin
    quick_res = '{raddr: vpage_in, wok: 1'b1, fault: FLT_NONE, word: '0};
    quick_end = 1'b1;
    if (xlate_en) begin
      if (!mode_ok || !range_ok)
        quick_res = '{raddr: '0, wok: 1'b0, fault: FLT_SPEC,
                      word: vpage_in | VA_W'(req_mode)};
      else if (!real_space)
        quick_end = 1'b0;
    end
  end

  // Result of a response that ends the walk
  walk_res_t rsp_res;
  always_comb begin
    if (ev_fault != FLT_NONE)
      rsp_res = '{raddr: '0, wok: 1'b0, fault: ev_fault,
                  word: vpage_q | VA_W'(mode_q)
                        | ((ev_fault == FLT_PROT) ? VA_W'(4) : '0)};
    else
      rsp_res = '{raddr: ev_frame, wok: ev_wok, fault: FLT_NONE, word: '0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      vpage_q   <= '0;
      wr_q      <= 1'b0;
      mode_q    <= '0;
      lvl_q     <= '0;
      at_page_q <= 1'b0;
      origin_q  <= '0;
      res_q     <= '{raddr: '0, wok: 1'b0, fault: FLT_NONE, word: '0};
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vpage_q   <= vpage_in;
            wr_q      <= req_write;
            mode_q    <= req_mode;
            lvl_q     <= start_lvl;
            at_page_q <= 1'b0;
            origin_q  <= root_origin;
            if (quick_end) begin
              res_q <= quick_res;
              state <= ST_DONE;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (ev_fault != FLT_NONE || at_page_q) begin
              res_q <= rsp_res;
              state <= ST_DONE;
            end else begin
              origin_q <= ev_next;
              if (lvl_q == '0) at_page_q <= 1'b1;
              else             lvl_q     <= lvl_q - 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign done          = (state == ST_DONE);
  assign res_raddr     = res_q.raddr;
  assign res_write_ok  = res_q.wok;
  assign res_fault     = res_q.fault;
  assign res_exc_word  = res_q.word;

  logic unused_va_low;
  assign unused_va_low = ^req_vaddr[PAGE_SHIFT-1:0];
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        done,
  input logic [63:0] res_raddr,
  input logic        res_write_ok,
  input logic [2:0]  res_fault,
  input logic [63:0] res_exc_word
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !done));

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  a_r9_ok_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == 3'd0) |-> (res_raddr[11:0] == 12'h0 && res_exc_word == 64'h0));

  a_r9_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault != 3'd0) |-> (res_raddr == 64'h0 && !res_write_ok));

  a_r8_prot_word: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault == 3'd4) |-> res_exc_word[2]);

  a_r7_fault_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_fault <= 3'd4));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .res_raddr     (res_raddr),
  .res_write_ok  (res_write_ok),
  .res_fault     (res_fault),
  .res_exc_word  (res_exc_word)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b1;
  logic [63:0] rp, rs, rh;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [63:0] res_raddr;
  logic        res_write_ok;
  logic [2:0]  res_fault;
  logic [63:0] res_exc_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en),
    .root_pri(rp), .root_sec(rs), .root_home(rh),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_mode(req_mode),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .res_raddr(res_raddr),
    .res_write_ok(res_write_ok), .res_fault(res_fault), .res_exc_word(res_exc_word)
  );

  int checks = 0;
  int errors = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_reads [$];
  int          rd_idx = 0;
  bit          busy = 1'b0;
  bit          stall_en = 1'b0;
  string       cur_tag = "";
  logic [63:0] next_tab = 64'h10_0000;
  logic [63:0] ex_r, ex_word;
  logic        ex_w;
  logic [2:0]  ex_f;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // Behavioural reference of one translation
  task automatic ref_walk(input logic [63:0] va, input bit wr, input logic [1:0] md, input bit en);
    logic [63:0] vp, root, org, a, e;
    int typ;
    exp_reads.delete();
    vp = {va[63:12], 12'h0};
    ex_f = 0; ex_r = 0; ex_w = 0; ex_word = 0;
    if (!en) begin ex_r = vp; ex_w = 1; return; end
    if (md == 0) begin ex_f = 1; ex_word = vp; return; end
    root = (md == 1) ? rp : (md == 2) ? rs : rh;
    typ = int'(root[3:2]);
    if ((typ == 2 && (vp & 64'hffe0_0000_0000_0000) != 0) ||
        (typ == 1 && (vp & 64'hffff_fc00_0000_0000) != 0) ||
        (typ == 0 && (vp & 64'hffff_ffff_8000_0000) != 0)) begin
      ex_f = 1; ex_word = vp | 64'(md); return;
    end
    if (root[5]) begin ex_r = vp; ex_w = 1; return; end
    org = {root[63:12], 12'h0};
    for (int k = typ; k >= 0; k--) begin
      a = org + ((vp >> (17 + 11*k)) & 64'h3ff8);
      exp_reads.push_back(a);
      e = rd(a);
      if (e[5]) begin ex_f = 2; ex_word = vp | 64'(md); return; end
      if (int'(e[3:2]) != k) begin ex_f = 1; ex_word = vp | 64'(md); return; end
      org = (k > 0) ? {e[63:12], 12'h0} : {e[63:11], 11'h0};
    end
    a = org + ((vp >> 9) & 64'h7f8);
    exp_reads.push_back(a);
    e = rd(a);
    if (e[10]) begin ex_f = 3; ex_word = vp | 64'(md); return; end
    if (e[9] && wr) begin ex_f = 4; ex_word = vp | 64'(md) | 64'd4; return; end
    ex_r = {e[63:12], 12'h0};
    ex_w = !e[9];
  endtask

  // Build the tables for one mapping
  task automatic install(input logic [63:0] root, input logic [63:0] va,
                         input logic [63:0] frame, input logic [63:0] pbits);
    logic [63:0] org, a, vp;
    vp = {va[63:12], 12'h0};
    org = {root[63:12], 12'h0};
    for (int k = int'(root[3:2]); k >= 0; k--) begin
      a = org + ((vp >> (17 + 11*k)) & 64'h3ff8);
      if (!mem.exists(a)) begin
        mem[a] = next_tab | (64'(k) << 2);
        next_tab += 64'h4000;
      end
      org = (k > 0) ? {mem[a][63:12], 12'h0} : {mem[a][63:11], 11'h0};
    end
    mem[org + ((vp >> 9) & 64'h7f8)] = frame | pbits;
  endtask

  // Memory model, also checks the read stream every clock
  int cnt = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid <= 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= rd(mem_req_addr);
      end
    end
    if (rst_n) begin
      if (mem_req_valid && !busy)
        chk(0, "R10 read while idle", mem_req_addr, 64'h0);
      if (done && !busy)
        chk(0, "R10 done while idle", 64'(done), 64'h0);
    end
  end

  always @(negedge clk) begin
    #1;
    mem_req_ready = !stall_en || (cyc % 3 != 0);
    if (rst_n && mem_req_valid && mem_req_ready && cnt == 0) begin
      if (rd_idx < exp_reads.size())
        chk(mem_req_addr == exp_reads[rd_idx], {cur_tag, " read address"},
            mem_req_addr, exp_reads[rd_idx]);
      else
        chk(0, {cur_tag, " extra read"}, mem_req_addr, 64'h0);
      rd_idx++;
      cnt = stall_en ? 2 : 1;
    end
  end

  task automatic walk(input logic [63:0] va, input bit wr, input logic [1:0] md,
                      input bit en, input string tag);
    int n;
    ref_walk(va, wr, md, en);
    @(negedge clk);
    cur_tag = tag; rd_idx = 0; busy = 1'b1;
    xlate_en = en; req_vaddr = va; req_write = wr; req_mode = md; req_valid = 1'b1;
    chk(req_ready, {tag, " R10 ready when idle"}, 64'(req_ready), 64'h1);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    chk(done, {tag, " R10 completion"}, 64'(done), 64'h1);
    chk(res_fault == ex_f, {tag, " fault"}, 64'(res_fault), 64'(ex_f));
    chk(res_raddr == ex_r, {tag, " raddr"}, res_raddr, ex_r);
    chk(res_write_ok == ex_w, {tag, " write_ok"}, 64'(res_write_ok), 64'(ex_w));
    chk(res_exc_word == ex_word, {tag, " exc word"}, res_exc_word, ex_word);
    chk(rd_idx == exp_reads.size(), {tag, " read count"}, 64'(rd_idx), 64'(exp_reads.size()));
    @(negedge clk);
    chk(!done, {tag, " R10 done one cycle"}, 64'(done), 64'h0);
    busy = 1'b0;
  endtask

  task automatic corrupt_walk(input logic [63:0] va, input int idx,
                              input logic [63:0] flip, input string tag);
    logic [63:0] a, save;
    ref_walk(va, 0, 1, 1);
    a = exp_reads[idx];
    save = mem[a];
    mem[a] = save ^ flip;
    walk(va, 0, 1, 1, tag);
    mem[a] = save;
  endtask

  localparam logic [63:0] VA1 = 64'h1234_5678_9abc_d123;
  localparam logic [63:0] VA2 = 64'h0012_3456_789a_b456;
  localparam logic [63:0] VA3 = 64'h0000_0000_1234_5789;
  localparam logic [63:0] VA4 = 64'h1234_5678_9abc_e000;
  localparam logic [63:0] VA5 = 64'h2222_3333_4444_5000;

  initial begin
    rp = 64'h1_000C; rs = 64'h2_0008; rh = 64'h3_0000;
    install(rp, VA1, 64'hABC_D000, 64'h0);
    install(rp, VA4, 64'h9_9000, 64'h0);
    install(rp, VA5, 64'h6_6000, 64'h0);
    install(rs, VA2, 64'h5_5000, 64'h200);
    install(rh, VA3, 64'h7_7000, 64'h0);
    repeat (3) @(negedge clk);
    chk(req_ready, "R10 reset ready", 64'(req_ready), 64'h1);
    chk(!done, "R10 reset done", 64'(done), 64'h0);
    chk(!mem_req_valid, "R10 reset mem idle", 64'(mem_req_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    walk(VA1, 0, 1, 0, "R2 translation off");
    walk(VA1, 1, 0, 1, "R1 mode zero");
    walk(VA1, 0, 1, 1, "R1 R5 R9 primary read");
    walk(VA1 ^ 64'hfff, 1, 1, 1, "R12 low bits write");
    walk(VA4, 0, 1, 1, "R5 shared tables");
    walk(VA2, 0, 2, 1, "R1 R8 readonly read");
    walk(VA2, 1, 2, 1, "R8 readonly write");
    walk(VA3, 1, 3, 1, "R1 R5 home segment root");
    walk(64'h0020_0000_0000_0000, 0, 2, 1, "R3 range type2");
    walk(64'h0000_0000_8000_0000, 0, 3, 1, "R3 range type0");
    rs = 64'h2_0004;
    walk(64'h0000_0400_0000_0000, 0, 2, 1, "R3 range type1");
    rs = 64'h2_0008;
    rh = 64'h3_0020;
    walk(VA3, 1, 3, 1, "R4 real space");
    rh = 64'h3_0000;
    corrupt_walk(VA5, 1, 64'h20, "R7 invalid region");
    corrupt_walk(VA5, 3, 64'h20, "R7 invalid segment");
    corrupt_walk(VA5, 4, 64'h400, "R7 invalid page");
    corrupt_walk(VA5, 2, 64'h4, "R6 type mismatch");
    corrupt_walk(VA5, 0, 64'h24, "R7 invalid before type");
    stall_en = 1'b1;
    walk(VA1, 0, 1, 1, "R11 stalled primary");
    walk(VA3, 0, 3, 1, "R11 stalled home");
    walk(VA2, 1, 2, 1, "R11 stalled protection");
    stall_en = 1'b0;
    walk(VA5, 1, 1, 1, "R5 R9 plain write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule